// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain, pulled-up serial data lines: one toward a host and one toward a card. Either end may start a LOW. The block works out which side began it and copies that LOW onto the other line. It does this without ever locking itself into holding both lines down. Each side gives the block a sampled line level. For each side the block returns a pull-down enable and a short active pull-up enable that speeds up the next rising edge. All timing is counted in system-clock cycles and set by parameters.

The side whose line falls first becomes the master, and the other side becomes the slave. While a transfer is in progress, falling edges on the slave line are ignored. This matters because the slave line goes LOW as soon as the block pulls it down, and that LOW must not be mistaken for a new request. When the master line returns HIGH, the block lets go of the slave line and drives a timed pull-up pulse on it. After the pulse it goes back to idle.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, and whenever no transfer is in progress, all four drive enables (`host_pd`, `card_pd`, `host_pu`, `card_pu`) are 0.
- R2: Each line input passes through two synchronising flops. Number the rising clock edges 1, 2, 3 and so on, where edge 1 is the first edge at which the host line is sampled LOW and the card line is idle HIGH. Then `card_pd` becomes 1 after edge PROP_DLY+3.
- R3: The same holds with the sides exchanged: when the card line falls first, `host_pd` becomes 1 after edge PROP_DLY+3.
- R4: During a transfer the master's own pull-down and pull-up enables stay 0. The slave's line falling, which the block itself causes, never starts a transfer in the opposite direction.
- R5: Let edge L be the last edge at which the master line is sampled LOW, with L > PROP_DLY. The slave pull-down is released after edge L+3, so it is held for L−PROP_DLY cycles. At that same edge the slave pull-up enable becomes 1, and it stays 1 for exactly PU_WIDTH cycles.
- R6: After the pull-up pulse the block is idle again, and it accepts a new falling edge on either side.
- R7: If the master line is LOW for no more than PROP_DLY sampled edges, the slave is never pulled down and no pull-up pulse is produced.
- R8: If both lines are first sampled LOW at the same edge, the host side becomes master: `card_pd` is asserted and `host_pd` stays 0.
- R9: The pull-down enable and the pull-up enable of one side are never both 1 in the same cycle.
- R10: The controller state is one-hot, with exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_pd | output | 1 | 1 = pull the host line LOW |
| card_pd | output | 1 | 1 = pull the card line LOW |
| host_pu | output | 1 | 1 = active pull-up pulse on the host line |
| card_pu | output | 1 | 1 = active pull-up pulse on the card line |

## Verification
Several rules are checked by assertions on every cycle:
- the state is one-hot;
- no side has its pull-down and pull-up enabled together;
- the two pull-downs are never both on;
- a pull-up pulse only ever directly follows a pull-down on the same side.

Other behaviour can only be shown by the bench scenarios, which model the wired lines:
- the exact cycle of the delayed pull-down;
- how long the pull-down is held;
- the width of the pull-up pulse;
- the cutoff for short pulses;
- host priority when both lines fall together;
- back-to-back transfers in opposite directions.

// File: rtl/od_line_repeater.sv
module od_line_repeater #(
  parameter int PROP_DLY = 4,
  parameter int PU_WIDTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_in,
  input  logic card_in,
  output logic host_pd,
  output logic card_pd,
  output logic host_pu,
  output logic card_pu
);

  localparam int MAXC = (PROP_DLY > PU_WIDTH) ? PROP_DLY : PU_WIDTH;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  typedef enum logic [5:0] {
    IDLE    = 6'b000001,
    MH_WAIT = 6'b000010,
    MH_LOW  = 6'b000100,
    MC_WAIT = 6'b001000,
    MC_LOW  = 6'b010000,
    PULLUP  = 6'b100000
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [2:0]    h_sh, c_sh;
  logic          pu_card;

  logic h_s, c_s, fall_h, fall_c;
  assign h_s    = h_sh[1];
  assign c_s    = c_sh[1];
  assign fall_h = h_sh[2] & ~h_s;
  assign fall_c = c_sh[2] & ~c_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_sh <= '1;
      c_sh <= '1;
    end else begin
      h_sh <= {h_sh[1:0], host_in};
      c_sh <= {c_sh[1:0], card_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cnt     <= '0;
      pu_card <= 1'b0;
    end else begin
      unique case (state)
        IDLE: begin
          cnt <= '0;
          if (fall_h)      state <= MH_WAIT;
          else if (fall_c) state <= MC_WAIT;
        end
        MH_WAIT: begin
          if (h_s) state <= IDLE;
          else if (cnt == CW'(PROP_DLY - 1)) begin
            state <= MH_LOW;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        MC_WAIT: begin
          if (c_s) state <= IDLE;
          else if (cnt == CW'(PROP_DLY - 1)) begin
            state <= MC_LOW;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        MH_LOW: if (h_s) begin
          state   <= PULLUP;
          pu_card <= 1'b1;
          cnt     <= '0;
        end
        MC_LOW: if (c_s) begin
          state   <= PULLUP;
          pu_card <= 1'b0;
          cnt     <= '0;
        end
        PULLUP: begin
          if (cnt == CW'(PU_WIDTH - 1)) begin
            state <= IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign card_pd = (state == MH_LOW);
  assign host_pd = (state == MC_LOW);
  assign card_pu = (state == PULLUP) &  pu_card;
  assign host_pu = (state == PULLUP) & ~pu_card;

endmodule

// File: rtl/od_line_repeater_chk.sv
module od_line_repeater_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_pd,
  input logic       card_pd,
  input logic       host_pu,
  input logic       card_pu,
  input logic [5:0] state
);

  // R9
  host_side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pd && host_pu));

  // R9
  card_side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_pd && card_pu));

  // R4
  no_dual_pulldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pd && card_pd));

  // R10
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  // R5
  card_pu_follows_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pu) |-> $past(card_pd));

  // R5
  host_pu_follows_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_pu) |-> $past(host_pd));

  // R5
  card_release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_pd) |-> card_pu);

  // R5
  host_release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_pd) |-> host_pu);

endmodule

bind od_line_repeater od_line_repeater_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .host_pd (host_pd),
  .card_pd (card_pd),
  .host_pu (host_pu),
  .card_pu (card_pu),
  .state   (state)
);

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb_top;
  localparam int CLK_P = 10;
  localparam int PD    = 4;
  localparam int PW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_ext = 1'b0, card_ext = 1'b0;
  logic host_pd, card_pd, host_pu, card_pu;
  logic host_in, card_in;
  int   errs = 0, checks = 0;

  assign host_in = ~(host_ext | host_pd);
  assign card_in = ~(card_ext | card_pd);

  always #(CLK_P/2) clk = ~clk;

  od_line_repeater #(.PROP_DLY(PD), .PU_WIDTH(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_in(host_in), .card_in(card_in),
    .host_pd(host_pd), .card_pd(card_pd), .host_pu(host_pu), .card_pu(card_pu)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // side: 0 host drives, 1 card drives, 2 both together
  typedef struct packed { logic [1:0] side; logic [7:0] len; } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd10}, '{2'd1, 8'd10}, '{2'd0, 8'd4},
    '{2'd1, 8'd2},  '{2'd2, 8'd8},  '{2'd0, 8'd5}
  };

  task automatic run(input int side, input int len, input string rq);
    int first_pd = 0, n_pd = 0, n_pu = 0, bad_m = 0, cont = 0;
    bit card_master;
    card_master = (side == 1);
    @(negedge clk);
    host_ext = (side != 1);
    card_ext = (side != 0);
    for (int c = 1; c <= len + PW + 12; c++) begin
      @(negedge clk);
      if (card_master ? host_pd : card_pd) begin
        n_pd++;
        if (first_pd == 0) first_pd = c;
      end
      if (card_master ? host_pu : card_pu) n_pu++;
      if (card_master ? (card_pd | card_pu) : (host_pd | host_pu)) bad_m++;
      if ((host_pd & host_pu) | (card_pd & card_pu)) cont++;
      if (c == len) begin host_ext = 1'b0; card_ext = 1'b0; end
    end
    chk({rq, " slave pd first edge"}, first_pd, (len > PD) ? PD + 3 : 0);
    chk({rq, "/R5 pd length"}, n_pd, (len > PD) ? len - PD : 0);
    chk({rq, "/R5 pu width"}, n_pu, (len > PD) ? PW : 0);
    chk("R4 master side untouched", bad_m, 0);
    chk("R9 pd/pu exclusive", cont, 0);
    chk("R6 idle after pulse", {host_pd, card_pd, host_pu, card_pu}, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    #(CLK_P * 3 + 1);
    chk("R1 reset outputs", {host_pd, card_pd, host_pu, card_pu}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", {host_pd, card_pd, host_pu, card_pu}, 0);
    foreach (VECS[i]) begin
      case (VECS[i].side)
        2'd0: run(0, VECS[i].len, (VECS[i].len > PD) ? "R2" : "R7");
        2'd1: run(1, VECS[i].len, (VECS[i].len > PD) ? "R3" : "R7");
        default: run(2, VECS[i].len, "R8");
      endcase
    end
    // R7 boundary: exactly PROP_DLY+1 sampled LOW edges still relays
    run(1, PD + 1, "R3");
    // R6 back-to-back opposite directions
    run(0, 7, "R6");
    run(1, 7, "R6");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule